// File: doc/BRIEF.md
# Multichannel SAR Conversion Sequencer

This block is the digital controller of an eight-channel successive-approximation converter that samples all of its channels at the same moment. A rising edge on `cnv_start` freezes every channel and starts a conversion cycle. The block then connects the channels to one shared approximation engine, one channel after another, in ascending index order. For each channel it runs an 18-step binary search against an external comparator decision. Channels that are disabled are skipped.

Every channel has a 3-bit range code, and the block latches all of these codes at each start edge. The code decides whether the channel is converted at all. It also decides how the result is written: as two's complement for a bipolar range, or as straight binary for a unipolar range. The new codes of all channels are published together, in one cycle, after the last enabled channel finishes. At that point `busy` falls and `done` rises.

Top module: `sar_seq`

## Requirements
- R1: A rising edge of `cnv_start` sampled while the block is idle sets `busy` at that clock edge and latches all eight range codes. If `range_codes` changes later, or `cnv_start` is simply held high, the running cycle is unaffected and no new cycle starts.
- R2: Enabled channels are converted one at a time in ascending index order. Each channel takes exactly 18 clocks, and `sel_ch` shows the channel currently connected to the engine.
- R3: Each channel's search starts with trial code 0x20000 (MSB only) and works downward, one bit per clock. When `cmp_keep` is 1 at a clock edge, the bit under trial is kept; when it is 0, the bit is cleared. For an input level v, the search therefore ends with offset-binary code v, where v is the largest code whose trial satisfies trial ≤ v.
- R4: Range code 0 disables a channel. A disabled channel gets no conversion time and its published result is 0.
- R5: Odd range codes (1, 3, 5, 7) are bipolar. Their result is the offset-binary code with bit 17 inverted, which gives two's complement. Even nonzero codes (2, 4, 6) are unipolar, and their result is the offset-binary code unchanged.
- R6: `results` changes only on the clock edge where `done` rises. It stays stable for the whole of a cycle. Channel i occupies bits [18i+17:18i].
- R7: `done` rises and `busy` falls together, 18·N+1 clocks after the start edge, where N is the number of enabled channels. `done` stays high until the next accepted start edge, and is never high while `busy` is high.
- R8: A rising edge of `cnv_start` that arrives while `busy` is high is ignored.
- R9: If every range code is 0, the cycle ends one clock after the start edge and all results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_start | input | 1 | Convert start; its rising edge samples all channels |
| range_codes | input | 24 | Range code of channel i in bits [3i+2:3i] |
| cmp_keep | input | 1 | Comparator decision: 1 keeps the bit under trial |
| busy | output | 1 | High from the accepted start edge until done |
| done | output | 1 | High once every enabled channel is published |
| sel_ch | output | 3 | Channel currently connected to the engine |
| trial | output | 18 | Trial code applied to the DAC |
| results | output | 144 | Published formatted codes, 18 bits per channel |

## Verification
The hardest situations to reach are the ones where inputs change while a cycle is still running. These are a second start edge in the middle of a channel, range codes rewritten after the start edge, and `cnv_start` held high through the end of a cycle. The stimulus therefore deliberately pulses and holds `cnv_start`, and rewrites `range_codes`, partway through conversions. A behavioural model that ignores mid-cycle edges checks every clock that the timing and the published codes still follow the codes latched at the start edge. Sparse enable patterns (only the last channel, gaps between channels, or no channel at all) check the skipping logic. Input levels at 0, at mid-scale and at full-scale check the sign-bit inversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int RNG_W = 3;

    typedef logic [RNG_W-1:0] rng_code_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_FIN
    } seq_state_e;

    // A channel takes part in a cycle whenever its range code is nonzero.
    function automatic logic is_enabled(rng_code_t c);
        return c != '0;
    endfunction

    // Odd codes select a range that is symmetric about zero.
    function automatic logic is_bipolar(rng_code_t c);
        return c[0];
    endfunction

endpackage

// File: rtl/sar_chan_pick.sv
module sar_chan_pick #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input  logic [NCH-1:0] en,
    input  logic [CW:0]    from,
    output logic           found,
    output logic [CW-1:0]  idx
);
    // Lowest enabled channel whose index is at least 'from'.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (en[i] && ((CW+1)'(i) >= from)) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
    parameter int NBITS = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_keep,
    output logic [NBITS-1:0] trial,
    output logic             last,
    output logic [NBITS-1:0] final_code
);
    logic [NBITS-1:0] acc;
    logic [NBITS-1:0] mask;

    assign trial      = acc | mask;
    assign last       = mask[0];
    assign final_code = cmp_keep ? trial : acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            mask <= '0;
        end else if (load) begin
            acc  <= '0;
            mask <= {1'b1, {(NBITS-1){1'b0}}};
        end else if (step && (mask != '0)) begin
            acc  <= final_code;
            mask <= mask >> 1;
        end
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int NBITS = 18
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cnv_start,
    input  logic [NCH*RNG_W-1:0]   range_codes,
    input  logic                   cmp_keep,
    output logic                   busy,
    output logic                   done,
    output logic [$clog2(NCH)-1:0] sel_ch,
    output logic [NBITS-1:0]       trial,
    output logic [NCH*NBITS-1:0]   results
);
    localparam int CW = $clog2(NCH);

    seq_state_e       state;
    logic             cnv_q;
    logic             start_edge;
    logic [CW-1:0]    ch;
    rng_code_t        live  [NCH];
    rng_code_t        held  [NCH];
    logic [NCH-1:0]   en_live;
    logic [NCH-1:0]   en_held;
    logic [NBITS-1:0] work  [NCH];
    logic [NBITS-1:0] res_q [NCH];

    logic             first_found, next_found;
    logic [CW-1:0]    first_idx, next_idx;
    logic [CW:0]      next_from;
    logic             eng_load, eng_step, eng_last;
    logic [NBITS-1:0] eng_final, fmt_code;

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        assign live[g]    = range_codes[g*RNG_W +: RNG_W];
        assign en_live[g] = is_enabled(live[g]);
        assign en_held[g] = is_enabled(held[g]);
        assign results[g*NBITS +: NBITS] = res_q[g];
    end

    assign start_edge = cnv_start && !cnv_q;
    assign next_from  = {1'b0, ch} + 1'b1;

    sar_chan_pick #(.NCH(NCH), .CW(CW)) u_first (
        .en(en_live), .from((CW+1)'(0)), .found(first_found), .idx(first_idx)
    );

    sar_chan_pick #(.NCH(NCH), .CW(CW)) u_next (
        .en(en_held), .from(next_from), .found(next_found), .idx(next_idx)
    );

    assign eng_step = (state == ST_CONV);
    assign eng_load = ((state == ST_IDLE) && start_edge && first_found) ||
                      (eng_step && eng_last && next_found);

    sar_approx #(.NBITS(NBITS)) u_eng (
        .clk(clk), .rst(rst), .load(eng_load), .step(eng_step),
        .cmp_keep(cmp_keep), .trial(trial), .last(eng_last),
        .final_code(eng_final)
    );

    // Bipolar: offset binary to two's complement by flipping the MSB.
    assign fmt_code = is_bipolar(held[ch])
                    ? {~eng_final[NBITS-1], eng_final[NBITS-2:0]}
                    : eng_final;

    assign sel_ch = ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnv_q <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
            ch    <= '0;
            for (int i = 0; i < NCH; i++) begin
                held[i]  <= '0;
                work[i]  <= '0;
                res_q[i] <= '0;
            end
        end else begin
            cnv_q <= cnv_start;
            unique case (state)
                ST_IDLE: begin
                    if (start_edge) begin
                        busy <= 1'b1;
                        done <= 1'b0;
                        for (int i = 0; i < NCH; i++) begin
                            held[i] <= live[i];
                            work[i] <= '0;
                        end
                        if (first_found) begin
                            ch    <= first_idx;
                            state <= ST_CONV;
                        end else begin
                            state <= ST_FIN;
                        end
                    end
                end
                ST_CONV: begin
                    if (eng_last) begin
                        work[ch] <= fmt_code;
                        if (next_found) begin
                            ch <= next_idx;
                        end else begin
                            state <= ST_FIN;
                        end
                    end
                end
                ST_FIN: begin
                    for (int i = 0; i < NCH; i++) begin
                        res_q[i] <= work[i];
                    end
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_W = 144
) (
    input logic             clk,
    input logic             rst,
    input logic             cnv_start,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] results
);
    // R7: done and busy never overlap
    a_r7_done_excl_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R7: done rises exactly as busy falls
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $fell(busy));

    // R7: done is held until a new cycle starts
    a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(done) && !busy) |-> done);

    // R6: published codes stay put during a cycle
    a_r6_results_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(results));

    // R1: a cycle only begins from a start request
    a_r1_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cnv_start));
endmodule

bind sar_seq sar_seq_chk #(.RES_W(NCH*NBITS)) u_chk (
    .clk(clk), .rst(rst), .cnv_start(cnv_start),
    .busy(busy), .done(done), .results(results)
);

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
    localparam int NCH = 8;
    localparam int NB  = 18;
    localparam int SPC = 18;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cnv_start = 1'b0;
    logic [NCH*3-1:0]  range_codes = '0;
    logic              cmp_keep;
    logic              busy, done;
    logic [2:0]        sel_ch;
    logic [NB-1:0]     trial;
    logic [NCH*NB-1:0] results;

    logic [NB-1:0] vals [NCH];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    sar_seq u0 (
        .clk(clk), .rst(rst), .cnv_start(cnv_start), .range_codes(range_codes),
        .cmp_keep(cmp_keep), .busy(busy), .done(done), .sel_ch(sel_ch),
        .trial(trial), .results(results)
    );

    // Analog model: comparator keeps the trial bit if trial <= sampled level.
    assign cmp_keep = (trial <= vals[sel_ch]);

    // ---------------- behavioural reference model ----------------
    bit            m_busy, m_done, m_prev;
    int            m_left, m_step;
    int            m_q[$];
    logic [2:0]    m_codes [NCH];
    logic [NB-1:0] m_vals  [NCH];
    logic [NCH*NB-1:0] m_res;

    function automatic logic [NB-1:0] expect_code(logic [2:0] c, logic [NB-1:0] v);
        if (c == 3'd0) return '0;
        if (c[0]) return v ^ (1 << (NB - 1));
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_prev = 0; m_left = 0; m_step = 0;
            m_res  = '0;
            m_q.delete();
        end else begin
            if (!m_busy) begin
                if (cnv_start && !m_prev) begin
                    m_busy = 1; m_done = 0; m_step = 0;
                    m_q.delete();
                    for (int i = 0; i < NCH; i++) begin
                        m_codes[i] = range_codes[i*3 +: 3];
                        m_vals[i]  = vals[i];
                        if (m_codes[i] != 0) m_q.push_back(i);
                    end
                    m_left = SPC * m_q.size() + 1;
                end
            end else begin
                m_left--;
                m_step++;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    for (int i = 0; i < NCH; i++)
                        m_res[i*NB +: NB] = expect_code(m_codes[i], m_vals[i]);
                end
            end
            m_prev = cnv_start;
        end
    end

    task automatic check_eq(string tag, logic [NCH*NB-1:0] act, logic [NCH*NB-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            check_eq("R7 busy", {{(NCH*NB-1){1'b0}}, busy}, {{(NCH*NB-1){1'b0}}, m_busy});
            check_eq("R7 done", {{(NCH*NB-1){1'b0}}, done}, {{(NCH*NB-1){1'b0}}, m_done});
            check_eq("R6 results", results, m_res);
            if (m_busy && m_step < SPC * m_q.size()) begin
                check_eq("R2 sel_ch", {{(NCH*NB-3){1'b0}}, sel_ch},
                         (NCH*NB)'(m_q[m_step / SPC]));
                if (m_step % SPC == 0)
                    check_eq("R3 first trial", (NCH*NB)'(trial), (NCH*NB)'(1 << (NB - 1)));
            end
        end
    end

    task automatic run(logic [NCH*3-1:0] codes);
        @(negedge clk);
        range_codes = codes;
        cnv_start   = 1'b1;
        @(negedge clk);
        cnv_start   = 1'b0;
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [NCH*3-1:0] pack(int c0, int c1, int c2, int c3,
                                              int c4, int c5, int c6, int c7);
        return {3'(c7), 3'(c6), 3'(c5), 3'(c4), 3'(c3), 3'(c2), 3'(c1), 3'(c0)};
    endfunction

    function automatic logic [NCH*NB-1:0] slot(int ch, logic [NB-1:0] v);
        logic [NCH*NB-1:0] r = '0;
        r[ch*NB +: NB] = v;
        return r;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) vals[i] = NB'(i * 33333 + 17);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R7 reset state", {busy, done, results}, '0);

        // All bipolar code 7, boundary levels included (R5, R3)
        vals[0] = 18'h00000; vals[1] = 18'h3FFFF; vals[2] = 18'h20000; vals[3] = 18'h1FFFF;
        run(pack(7, 7, 7, 7, 7, 7, 7, 7));
        check_eq("R5 bipolar zero level", results & slot(0, '1), slot(0, 18'h20000));
        check_eq("R5 bipolar full level", results & slot(1, '1), slot(1, 18'h1FFFF));
        check_eq("R3 mid-scale search", results & slot(2, '1), slot(2, 18'h00000));

        // Unipolar mix with gaps (R4, R5)
        vals[4] = 18'h2ABCD; vals[6] = 18'h01234;
        run(pack(0, 2, 0, 4, 6, 0, 3, 0));
        check_eq("R4 disabled zero", results & slot(0, '1), '0);
        check_eq("R5 unipolar straight", results & slot(4, '1), slot(4, 18'h2ABCD));
        check_eq("R5 bipolar code 3", results & slot(6, '1), slot(6, 18'h21234));

        // Only the last channel (R4, R2)
        run(pack(0, 0, 0, 0, 0, 0, 0, 5));
        check_eq("R4 lone channel", results, slot(7, vals[7] ^ 18'h20000));

        // Everything disabled (R9)
        run('0);
        check_eq("R9 all disabled", results, '0);

        // Mid-cycle start pulse and code rewrite (R8, R1)
        @(negedge clk);
        range_codes = pack(2, 2, 2, 2, 0, 0, 0, 0);
        cnv_start = 1'b1;
        @(negedge clk);
        cnv_start = 1'b0;
        repeat (25) @(negedge clk);
        cnv_start = 1'b1;
        range_codes = pack(7, 7, 7, 7, 7, 7, 7, 7);
        @(negedge clk);
        cnv_start = 1'b0;
        check_eq("R8 still busy after ignored start", {{(NCH*NB-1){1'b0}}, busy},
                 {{(NCH*NB-1){1'b0}}, 1'b1});
        while (m_busy) @(negedge clk);
        @(negedge clk);
        check_eq("R1 latched unipolar codes", results & slot(1, '1), slot(1, vals[1]));
        check_eq("R1 new codes ignored", results & slot(5, '1), '0);

        // Start held high: only one cycle (R1)
        @(negedge clk);
        range_codes = pack(1, 0, 0, 0, 0, 0, 0, 0);
        cnv_start = 1'b1;
        repeat (SPC + 6) @(negedge clk);
        check_eq("R1 held start no restart", {{(NCH*NB-2){1'b0}}, busy, done},
                 (NCH*NB)'(1));
        cnv_start = 1'b0;
        repeat (2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule